// File: doc/BRIEF.md
# Set-Associative Cache Tag Controller

This block holds the tag, valid flag and saved physical line address for every line of a set-associative cache with a fixed number of sets and ways. Requests arrive on a single command port. Each request names an operation, an address word and a physical address. The supported operations are:

- a lookup;
- an allocation that picks its victim with a round-robin pointer kept per set;
- a clean or invalidate chosen by address, by a packed set/way index word, or by physical flush address;
- an invalidate of every line.

Lines that must be written back are passed to an external write-back sequencer, which answers with a done strobe. In write-back mode an allocation refills its line with a burst of 32-bit word reads. The data array and the memory sit outside the block.

Each request ends with a single-cycle done pulse. The pulse carries a hit flag and a way number. No new request is accepted until the previous one has completed.

Top module: `cache_tag_ctrl`

## Requirements
- R1: After reset every line is invalid, every per-set victim pointer is zero, `req_ready` is high, and `done`, `wb_req` and `rd_req` are low.
- R2: A lookup uses `req_addr[OFF_W+SET_W-1:OFF_W]` as the set and `req_addr[31:OFF_W]` as the tag. It hits only on a valid way with an equal tag. On a hit, `done_way` reports that way; on a miss, `done_hit` and `done_way` are 0.
- R3: Every allocation in a set takes the way named by that set's pointer and advances the pointer, wrapping to way 0 after the last way. Each set's pointer is independent of the others.
- R4: In write-back mode an allocation first writes back a valid victim, with `wb_pa` equal to the line's saved physical address. It then issues LINE_BYTES/4 word reads at the line-aligned `req_pa` plus 0, 4, 8 and so on, in ascending order, and never reads while `wb_req` is high.
- R5: After an allocation, a lookup of any address in the same line hits the allocated way.
- R6: Clean by address (op 2) writes back the matching line only on a hit. The line stays valid.
- R7: Invalidate by address (op 3) writes back the matching line on a hit and then clears it.
- R8: Clean by index (op 4) and invalidate by index (op 5) take the way from `req_addr[31:32-WAY_W]` and the set from `req_addr[OFF_W+SET_W-1:OFF_W]`. A write-back happens, and `done_hit` is 1, only if that line is valid. Invalidate clears the line; clean keeps it.
- R9: Flush by physical address (op 6) takes the way from `req_addr[OFF_W+WAY_W-1:OFF_W]` and the set from the next SET_W bits. It writes the line back if it is valid and then clears it.
- R10: Invalidate-all (op 7) visits lines set by set and way by way, in ascending order. It writes back each valid line, leaves every line invalid, and holds `req_ready` low until it finishes.
- R11: Every accepted request yields exactly one single-cycle `done` pulse. `wb_req` and `wb_pa` stay steady until `wb_done`.

Operation codes on `req_op`: 0 lookup, 1 allocate, 2 clean by address, 3 invalidate by address, 4 clean by index, 5 invalidate by index, 6 flush by physical address, 7 invalidate all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_op | input | 3 | Operation code |
| req_addr | input | 32 | Virtual address, index word or flush address |
| req_pa | input | 32 | Physical address for allocation |
| req_ready | output | 1 | Controller idle and able to take a request |
| done | output | 1 | One-cycle completion pulse |
| done_hit | output | 1 | Line matched or was valid |
| done_way | output | log2(NUM_WAYS) | Way that was used |
| wb_req | output | 1 | Write-back of a line requested |
| wb_pa | output | 32 | Line-aligned physical address to write back |
| wb_done | input | 1 | Write-back sequencer finished |
| rd_req | output | 1 | Refill word read request |
| rd_addr | output | 32 | Refill word address |
| rd_ack | input | 1 | Refill word accepted |

## Verification
The assertions assume two things about the inputs. First, no allocation is made for a line address that is already present, so at most one way of a set can ever match. Second, `wb_done` and `rd_ack` are raised only while the matching request is high. The stimulus keeps to both. Every allocated virtual line in the vector table is distinct from the lines still cached. The memory and write-back models in the bench answer only when they see an active request, and they drive their answers on the falling edge.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;

    typedef enum logic [2:0] {
        OP_LOOKUP    = 3'd0,
        OP_ALLOC     = 3'd1,
        OP_CLEAN_VA  = 3'd2,
        OP_INV_VA    = 3'd3,
        OP_CLEAN_IDX = 3'd4,
        OP_INV_IDX   = 3'd5,
        OP_FLUSH_PA  = 3'd6,
        OP_INV_ALL   = 3'd7
    } ctag_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WB,
        ST_FILL,
        ST_WALK
    } ctag_state_e;

    // Operations that leave the selected line invalid once any write-back is done
    function automatic logic op_clears(ctag_op_e op);
        return (op == OP_INV_VA) || (op == OP_INV_IDX) ||
               (op == OP_FLUSH_PA) || (op == OP_INV_ALL);
    endfunction

endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
    parameter int NUM_SETS = 8,
    parameter int NUM_WAYS = 4,
    parameter int TAG_W    = 28,
    localparam int SET_W   = $clog2(NUM_SETS),
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic [WAY_W-1:0] lk_way,
    input  logic [SET_W-1:0] rd_set,
    input  logic [WAY_W-1:0] rd_way,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_pa,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  logic [WAY_W-1:0] wr_way,
    input  logic             wr_valid,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [TAG_W-1:0] wr_pa
);
    logic             valid_q [NUM_SETS][NUM_WAYS];
    logic [TAG_W-1:0] tag_q   [NUM_SETS][NUM_WAYS];
    logic [TAG_W-1:0] pa_q    [NUM_SETS][NUM_WAYS];
    logic [NUM_WAYS-1:0] match;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        assign match[w] = valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);

        always_ff @(posedge clk) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                if (rst) begin
                    valid_q[s][w] <= 1'b0;
                end else if (wr_en && wr_way == WAY_W'(w) && wr_set == SET_W'(s)) begin
                    valid_q[s][w] <= wr_valid;
                    tag_q[s][w]   <= wr_tag;
                    pa_q[s][w]    <= wr_pa;
                end
            end
        end
    end

    always_comb begin
        lk_hit = 1'b0;
        lk_way = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (match[w]) begin
                lk_hit = 1'b1;
                lk_way = WAY_W'(w);
            end
        end
    end

    assign rd_valid = valid_q[rd_set][rd_way];
    assign rd_pa    = pa_q[rd_set][rd_way];

    p_single_match_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));

endmodule

// File: rtl/cache_victim_ptr.sv
module cache_victim_ptr #(
    parameter int NUM_SETS = 8,
    parameter int NUM_WAYS = 4,
    localparam int SET_W   = $clog2(NUM_SETS),
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] sel_set,
    output logic [WAY_W-1:0] victim,
    input  logic             adv_en
);
    logic [WAY_W-1:0] ptr_q [NUM_SETS];

    assign victim = ptr_q[sel_set];

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        always_ff @(posedge clk) begin
            if (rst) begin
                ptr_q[s] <= '0;
            end else if (adv_en && sel_set == SET_W'(s)) begin
                ptr_q[s] <= (ptr_q[s] == WAY_W'(NUM_WAYS - 1)) ? '0 : ptr_q[s] + 1'b1;
            end
        end
    end

    p_ptr_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        adv_en && victim == WAY_W'(NUM_WAYS - 1) |=> ptr_q[$past(sel_set)] == '0);

endmodule

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl
    import cache_tag_pkg::*;
#(
    parameter int LINE_BYTES = 16,
    parameter int NUM_WAYS   = 4,
    parameter int NUM_SETS   = 8,
    parameter bit WRITE_BACK = 1'b1,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int SET_W     = $clog2(NUM_SETS),
    localparam int WAY_W     = $clog2(NUM_WAYS),
    localparam int TAG_W     = 32 - OFF_W,
    localparam int WORDS     = LINE_BYTES / 4,
    localparam int CNT_W     = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [2:0]       req_op,
    input  logic [31:0]      req_addr,
    input  logic [31:0]      req_pa,
    output logic             req_ready,
    output logic             done,
    output logic             done_hit,
    output logic [WAY_W-1:0] done_way,
    output logic             wb_req,
    output logic [31:0]      wb_pa,
    input  logic             wb_done,
    output logic             rd_req,
    output logic [31:0]      rd_addr,
    input  logic             rd_ack
);
    ctag_state_e      state_q, state_d;
    ctag_op_e         op_q, op_d, op_in;
    logic [SET_W-1:0] cur_set_q, cur_set_d, sel_set, rd_set, a_set;
    logic [WAY_W-1:0] cur_way_q, cur_way_d, sel_way, rd_way, vic_way, lk_way;
    logic [TAG_W-1:0] new_tag_q, new_tag_d, fill_q, fill_d, rd_pa;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             hit_q, hit_d, done_q, done_d;
    logic [WAY_W-1:0] way_q, way_d;
    logic             lk_hit, rd_valid, adv_en, last_line;
    logic             wr_en, wr_valid;
    logic [SET_W-1:0] wr_set;
    logic [WAY_W-1:0] wr_way;
    logic [TAG_W-1:0] wr_tag, wr_pa;

    assign op_in = ctag_op_e'(req_op);
    assign a_set = req_addr[OFF_W +: SET_W];

    // Line selection for the request presented while idle
    always_comb begin
        case (op_in)
            OP_CLEAN_IDX, OP_INV_IDX: begin
                sel_set = a_set;
                sel_way = req_addr[31 -: WAY_W];
            end
            OP_FLUSH_PA: begin
                sel_set = req_addr[OFF_W + WAY_W +: SET_W];
                sel_way = req_addr[OFF_W +: WAY_W];
            end
            OP_ALLOC: begin
                sel_set = a_set;
                sel_way = vic_way;
            end
            default: begin
                sel_set = a_set;
                sel_way = lk_way;
            end
        endcase
    end

    assign rd_set    = (state_q == ST_IDLE) ? sel_set : cur_set_q;
    assign rd_way    = (state_q == ST_IDLE) ? sel_way : cur_way_q;
    assign last_line = (cur_set_q == SET_W'(NUM_SETS - 1)) && (cur_way_q == WAY_W'(NUM_WAYS - 1));

    cache_tag_store #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W)) i_store (
        .clk(clk), .rst(rst),
        .lk_set(a_set), .lk_tag(req_addr[31:OFF_W]), .lk_hit(lk_hit), .lk_way(lk_way),
        .rd_set(rd_set), .rd_way(rd_way), .rd_valid(rd_valid), .rd_pa(rd_pa),
        .wr_en(wr_en), .wr_set(wr_set), .wr_way(wr_way), .wr_valid(wr_valid),
        .wr_tag(wr_tag), .wr_pa(wr_pa)
    );

    cache_victim_ptr #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) i_vptr (
        .clk(clk), .rst(rst), .sel_set(a_set), .victim(vic_way), .adv_en(adv_en)
    );

    always_comb begin
        state_d   = state_q;
        op_d      = op_q;
        cur_set_d = cur_set_q;
        cur_way_d = cur_way_q;
        new_tag_d = new_tag_q;
        fill_d    = fill_q;
        cnt_d     = cnt_q;
        hit_d     = hit_q;
        way_d     = way_q;
        done_d    = 1'b0;
        adv_en    = 1'b0;
        wr_en     = 1'b0;
        wr_set    = cur_set_q;
        wr_way    = cur_way_q;
        wr_valid  = 1'b0;
        wr_tag    = '0;
        wr_pa     = '0;
        unique case (state_q)
            ST_IDLE: if (req_valid) begin
                op_d      = op_in;
                cur_set_d = sel_set;
                cur_way_d = sel_way;
                hit_d     = 1'b0;
                way_d     = '0;
                case (op_in)
                    OP_LOOKUP: begin
                        done_d = 1'b1;
                        hit_d  = lk_hit;
                        way_d  = lk_way;
                    end
                    OP_CLEAN_VA, OP_INV_VA: begin
                        hit_d = lk_hit;
                        way_d = lk_way;
                        if (lk_hit) state_d = ST_WB;
                        else        done_d  = 1'b1;
                    end
                    OP_CLEAN_IDX, OP_INV_IDX, OP_FLUSH_PA: begin
                        hit_d = rd_valid;
                        way_d = sel_way;
                        if (rd_valid) begin
                            state_d = ST_WB;
                        end else begin
                            done_d = 1'b1;
                            wr_en  = op_clears(op_in);
                            wr_set = sel_set;
                            wr_way = sel_way;
                        end
                    end
                    OP_ALLOC: begin
                        adv_en    = 1'b1;
                        way_d     = vic_way;
                        new_tag_d = req_addr[31:OFF_W];
                        fill_d    = req_pa[31:OFF_W];
                        cnt_d     = '0;
                        if (WRITE_BACK && rd_valid) begin
                            state_d = ST_WB;
                        end else if (WRITE_BACK) begin
                            state_d = ST_FILL;
                        end else begin
                            done_d   = 1'b1;
                            wr_en    = 1'b1;
                            wr_set   = a_set;
                            wr_way   = vic_way;
                            wr_valid = 1'b1;
                            wr_tag   = req_addr[31:OFF_W];
                            wr_pa    = req_pa[31:OFF_W];
                        end
                    end
                    default: begin
                        cur_set_d = '0;
                        cur_way_d = '0;
                        state_d   = ST_WALK;
                    end
                endcase
            end
            ST_WB: if (wb_done) begin
                wr_en = op_clears(op_q);
                if (op_q == OP_ALLOC) begin
                    state_d = ST_FILL;
                end else if (op_q == OP_INV_ALL) begin
                    state_d = ST_WALK;
                end else begin
                    state_d = ST_IDLE;
                    done_d  = 1'b1;
                end
            end
            ST_FILL: if (rd_ack) begin
                cnt_d = cnt_q + 1'b1;
                if (cnt_q == CNT_W'(WORDS - 1)) begin
                    wr_en    = 1'b1;
                    wr_valid = 1'b1;
                    wr_tag   = new_tag_q;
                    wr_pa    = fill_q;
                    state_d  = ST_IDLE;
                    done_d   = 1'b1;
                end
            end
            ST_WALK: begin
                if (rd_valid) begin
                    state_d = ST_WB;
                end else if (last_line) begin
                    state_d = ST_IDLE;
                    done_d  = 1'b1;
                end else if (cur_way_q == WAY_W'(NUM_WAYS - 1)) begin
                    cur_way_d = '0;
                    cur_set_d = cur_set_q + 1'b1;
                end else begin
                    cur_way_d = cur_way_q + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            op_q      <= OP_LOOKUP;
            cur_set_q <= '0;
            cur_way_q <= '0;
            new_tag_q <= '0;
            fill_q    <= '0;
            cnt_q     <= '0;
            hit_q     <= 1'b0;
            way_q     <= '0;
            done_q    <= 1'b0;
        end else begin
            state_q   <= state_d;
            op_q      <= op_d;
            cur_set_q <= cur_set_d;
            cur_way_q <= cur_way_d;
            new_tag_q <= new_tag_d;
            fill_q    <= fill_d;
            cnt_q     <= cnt_d;
            hit_q     <= hit_d;
            way_q     <= way_d;
            done_q    <= done_d;
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign done      = done_q;
    assign done_hit  = hit_q;
    assign done_way  = way_q;
    assign wb_req    = (state_q == ST_WB);
    assign wb_pa     = {rd_pa, {OFF_W{1'b0}}};
    assign rd_req    = (state_q == ST_FILL);
    assign rd_addr   = {fill_q, {OFF_W{1'b0}}} + {cnt_q, 2'b00};

    p_wb_hold_r11: assert property (@(posedge clk) disable iff (rst)
        wb_req && !wb_done |=> wb_req && $stable(wb_pa));

    p_no_overlap_r4: assert property (@(posedge clk) disable iff (rst)
        !(wb_req && rd_req));

    p_fill_step_r4: assert property (@(posedge clk) disable iff (rst)
        rd_req && rd_ack && (rd_addr[OFF_W-1:0] != OFF_W'(LINE_BYTES - 4))
        |=> rd_req && rd_addr == $past(rd_addr) + 32'd4);

    p_walk_busy_r10: assert property (@(posedge clk) disable iff (rst)
        $past(req_valid && req_ready && req_op == 3'd7) |-> !req_ready);

endmodule

// File: tb/test_cache_tag_ctrl.sv
module test_cache_tag_ctrl;

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] addr;
        logic [31:0] pa;
        logic        hit;
        logic [1:0]  way;
        logic [3:0]  nrd;
        logic [1:0]  nwb;
        logic [31:0] wbpa;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 32'h100,       32'h0,    1'b0, 2'd0, 4'd0, 2'd0, 32'h0},
        '{3'd1, 32'h100,       32'h8000, 1'b0, 2'd0, 4'd4, 2'd0, 32'h0},
        '{3'd0, 32'h10C,       32'h0,    1'b1, 2'd0, 4'd0, 2'd0, 32'h0},
        '{3'd1, 32'h200,       32'h9000, 1'b0, 2'd1, 4'd4, 2'd0, 32'h0},
        '{3'd1, 32'h300,       32'hA000, 1'b0, 2'd2, 4'd4, 2'd0, 32'h0},
        '{3'd1, 32'h400,       32'hB000, 1'b0, 2'd3, 4'd4, 2'd0, 32'h0},
        '{3'd1, 32'h500,       32'hC000, 1'b0, 2'd0, 4'd4, 2'd1, 32'h8000},
        '{3'd0, 32'h100,       32'h0,    1'b0, 2'd0, 4'd0, 2'd0, 32'h0},
        '{3'd0, 32'h500,       32'h0,    1'b1, 2'd0, 4'd0, 2'd0, 32'h0},
        '{3'd2, 32'h200,       32'h0,    1'b1, 2'd1, 4'd0, 2'd1, 32'h9000},
        '{3'd0, 32'h204,       32'h0,    1'b1, 2'd1, 4'd0, 2'd0, 32'h0},
        '{3'd2, 32'h700,       32'h0,    1'b0, 2'd0, 4'd0, 2'd0, 32'h0},
        '{3'd3, 32'h300,       32'h0,    1'b1, 2'd2, 4'd0, 2'd1, 32'hA000},
        '{3'd0, 32'h300,       32'h0,    1'b0, 2'd0, 4'd0, 2'd0, 32'h0},
        '{3'd1, 32'h610,       32'hD01C, 1'b0, 2'd0, 4'd4, 2'd0, 32'h0},
        '{3'd4, 32'hC000_0000, 32'h0,    1'b1, 2'd3, 4'd0, 2'd1, 32'hB000},
        '{3'd0, 32'h400,       32'h0,    1'b1, 2'd3, 4'd0, 2'd0, 32'h0},
        '{3'd5, 32'h4000_0000, 32'h0,    1'b1, 2'd1, 4'd0, 2'd1, 32'h9000},
        '{3'd0, 32'h200,       32'h0,    1'b0, 2'd0, 4'd0, 2'd0, 32'h0},
        '{3'd5, 32'h8000_0000, 32'h0,    1'b0, 2'd2, 4'd0, 2'd0, 32'h0},
        '{3'd6, 32'h40,        32'h0,    1'b1, 2'd0, 4'd0, 2'd1, 32'hD010},
        '{3'd0, 32'h610,       32'h0,    1'b0, 2'd0, 4'd0, 2'd0, 32'h0},
        '{3'd7, 32'h0,         32'h0,    1'b0, 2'd0, 4'd0, 2'd2, 32'hB000},
        '{3'd0, 32'h500,       32'h0,    1'b0, 2'd0, 4'd0, 2'd0, 32'h0},
        '{3'd0, 32'h400,       32'h0,    1'b0, 2'd0, 4'd0, 2'd0, 32'h0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_pa = '0;
    logic        req_ready, done, done_hit;
    logic [1:0]  done_way;
    logic        wb_req, rd_req;
    logic [31:0] wb_pa, rd_addr;
    logic        wb_done = 1'b0;
    logic        rd_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    int rd_cnt = 0;
    int wb_cnt = 0;
    logic [31:0] last_wb_pa = '0;
    logic [31:0] rd_log [8];
    logic [1:0]  wdly = '0;
    logic        got_hit;
    logic [1:0]  got_way;

    always #5 clk = ~clk;

    cache_tag_ctrl i_cache_tag_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_pa(req_pa), .req_ready(req_ready),
        .done(done), .done_hit(done_hit), .done_way(done_way),
        .wb_req(wb_req), .wb_pa(wb_pa), .wb_done(wb_done),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack)
    );

    // Write-back sequencer model: answers after a short delay
    always @(negedge clk) begin
        if (wb_req && !wb_done) begin
            if (wdly == 2'd2) begin
                wb_done <= 1'b1;
                last_wb_pa = wb_pa;
                wb_cnt++;
                wdly <= '0;
            end else begin
                wdly <= wdly + 1'b1;
            end
        end else begin
            wb_done <= 1'b0;
        end
    end

    // Memory model: one word per cycle while reads are requested
    always @(negedge clk) begin
        if (rd_req) begin
            rd_ack <= 1'b1;
            rd_log[rd_cnt[2:0]] = rd_addr;
            rd_cnt++;
        end else begin
            rd_ack <= 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_req(input logic [2:0] op, input logic [31:0] addr, input logic [31:0] pa);
        int guard;
        rd_cnt = 0;
        wb_cnt = 0;
        last_wb_pa = '0;
        req_op = op;
        req_addr = addr;
        req_pa = pa;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (!done && guard < 500) begin
            @(negedge clk);
            guard++;
        end
        got_hit = done_hit;
        got_way = done_way;
        check(done == 1'b1, "R11 done seen", 32'(done), 32'd1);
        @(negedge clk);
        check(done == 1'b0, "R11 done single cycle", 32'(done), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && !done && !wb_req && !rd_req, "R1 reset outputs",
              {28'd0, req_ready, done, wb_req, rd_req}, 32'h8);

        // Vector table covers R2..R10
        for (int i = 0; i < NV; i++) begin
            do_req(VECS[i].op, VECS[i].addr, VECS[i].pa);
            check(got_hit == VECS[i].hit, $sformatf("R2/R5/R6/R7/R8/R9 hit vec %0d", i),
                  32'(got_hit), 32'(VECS[i].hit));
            check(got_way == VECS[i].way, $sformatf("R3/R8/R9 way vec %0d", i),
                  32'(got_way), 32'(VECS[i].way));
            check(rd_cnt == int'(VECS[i].nrd), $sformatf("R4 read count vec %0d", i),
                  32'(rd_cnt), 32'(VECS[i].nrd));
            check(wb_cnt == int'(VECS[i].nwb), $sformatf("R6/R7/R10 wb count vec %0d", i),
                  32'(wb_cnt), 32'(VECS[i].nwb));
            check(last_wb_pa == VECS[i].wbpa, $sformatf("R4/R10 wb address vec %0d", i),
                  last_wb_pa, VECS[i].wbpa);
        end

        // R1: reset clears lines and pointers
        do_req(3'd1, 32'h800, 32'hF000);
        check(got_way == 2'd1, "R3 pointer before reset", 32'(got_way), 32'd1);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && !done, "R1 ready after reset", {30'd0, req_ready, done}, 32'h2);
        do_req(3'd0, 32'h800, 32'h0);
        check(got_hit == 1'b0, "R1 line invalid after reset", 32'(got_hit), 32'd0);
        do_req(3'd1, 32'h900, 32'hE00B);
        check(got_way == 2'd0, "R1 pointer zero after reset", 32'(got_way), 32'd0);
        check(wb_cnt == 0, "R4 invalid victim not written", 32'(wb_cnt), 32'd0);
        for (int k = 0; k < 4; k++) begin
            check(rd_log[k] == 32'hE000 + 32'(4 * k), "R4 refill address order",
                  rd_log[k], 32'hE000 + 32'(4 * k));
        end
        do_req(3'd0, 32'h90C, 32'h0);
        check(got_hit && got_way == 2'd0, "R5 hit after refill", {30'd0, got_hit, got_way[0]}, 32'h2);

        // R10: busy during the walk
        req_op = 3'd7;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R10 not ready during walk", 32'(req_ready), 32'd0);
        while (!done) @(negedge clk);
        @(negedge clk);
        do_req(3'd0, 32'h900, 32'h0);
        check(got_hit == 1'b0, "R10 line cleared by walk", 32'(got_hit), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule